// File: doc/BRIEF.md
# Key-Protected Watchdog Timer Register Block

This block is a watchdog timer whose control state can only be changed by 16-bit word writes that carry an 8-bit key in the upper byte and the payload in the lower byte. The count register and the timer control register share one write offset. The key alone decides which of the two is loaded. Any other key, any byte-sized write and any word write at an odd offset leaves all state untouched, and the bus sees no error. A separate reset status register holds a sticky watchdog-reset flag. Only one fixed key-and-data word clears that flag.

Once enabled, an 8-bit counter advances on ticks from a prescaler. A 3-bit field in the control register picks the prescaler ratio. When the counter wraps from 0xFF to 0x00, an overflow flag is set. The overflow flag can only be cleared, and only by a write of 0 that follows a read showing it as 1. In watchdog mode with reset enabled, a wrap also sets the reset flag and drives a reset output high for a fixed number of cycles. Reads are plain byte or word reads. A word read is big-endian, with the even byte in the upper half.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter is 0x00, the control byte reads 0x08, the reset status byte reads 0x3F and `wdt_reset_o` is low.
- R2: A word write at offset 0 with upper byte 0x5A loads the lower byte into the counter, and this load wins over a coincident tick.
- R3: A word write at offset 0 with upper byte 0xA5 loads the control fields: bit 6 watchdog mode, bit 5 timer enable, bit 4 reset enable, bits 2:0 prescaler select. Bit 3 always reads 1. A word write at offset 0 with any other key changes nothing.
- R4: Byte writes at any offset, and word writes at an odd offset, change no state.
- R5: The reset flag (bit 7 of the byte at offset 2) is cleared only by a word write at offset 2 whose whole value is 0xA500. Bit 6 of that byte reads 0 and bits 5:0 read 1.
- R6: While enabled with select s, the counter advances once every 2^(s+1) clock cycles, and the first advance comes 2^(s+1) cycles after the enabling write takes effect. While disabled the counter holds.
- R7: A counter wrap from 0xFF to 0x00 sets the overflow flag, which is bit 7 of the control byte.
- R8: A control write with bit 7 = 0 clears the overflow flag only if a read of the control byte has shown the flag as 1 since it was last cleared. A write with bit 7 = 1, or a write without such a read, leaves the flag set. A new overflow wins over a coincident clear.
- R9: A wrap while watchdog mode and reset enable are both set also sets the reset flag and holds `wdt_reset_o` high for exactly PULSE_CYCLES cycles. In interval mode a wrap touches neither the flag nor the output.
- R10: A byte read returns {0x00, byte} from offset 0 (control), 1 (counter), 2 (reset status) or 3 (0x00). A word read returns {byte[even], byte[even+1]} and ignores the low address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | Byte offset within the block |
| bus_wdata | input | 16 | Write word: key or check byte in [15:8], payload in [7:0] |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| wdt_reset_o | output | 1 | Watchdog reset pulse |

## Verification
The bench sends writes whose key matches neither register, byte writes that carry a valid key, and a word write at an odd offset. A decoder that looked at only part of the key, or ignored the access size, would change the counter or control readback. It samples the counter in the cycle just before and just after the first prescaler tick, so an off-by-one divider or a tick that starts at the wrong time shows up as a wrong count. It tries to clear the overflow flag before reading it and then with bit 7 set, and it tries to clear the reset flag with a near-miss data byte, a byte write and the other key. A design that cleared on any write would lose the flag early. Finally it measures the reset pulse width cycle by cycle and checks that interval mode gives no pulse.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [BYTE_W-1:0] KEY_COUNT   = 8'h5A;
  localparam logic [BYTE_W-1:0] KEY_CONTROL = 8'hA5;
  localparam logic [BYTE_W-1:0] FLAG_CLEAR  = 8'h00;

  localparam logic [1:0] OFS_SHARED = 2'd0;
  localparam logic [1:0] OFS_STATUS = 2'd2;

  localparam int CTL_OVF   = 7;
  localparam int CTL_MODE  = 6;
  localparam int CTL_EN    = 5;
  localparam int CTL_RSTEN = 4;

  typedef struct packed {
    logic load_count;
    logic load_control;
    logic clear_flag;
    logic read_control;
  } wdk_cmd_t;
endpackage

// File: rtl/wdk_bus_decode.sv
module wdk_bus_decode
  import wdk_pkg::*;
(
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output wdk_cmd_t    cmd
);
  logic word_wr_even;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] payload;

  assign key     = bus_wdata[15:8];
  assign payload = bus_wdata[7:0];

  always_comb begin
    word_wr_even      = bus_sel & bus_wr & bus_word & ~bus_addr[0];
    cmd.load_count    = word_wr_even & (bus_addr == OFS_SHARED) & (key == KEY_COUNT);
    cmd.load_control  = word_wr_even & (bus_addr == OFS_SHARED) & (key == KEY_CONTROL);
    cmd.clear_flag    = word_wr_even & (bus_addr == OFS_STATUS) & (key == KEY_CONTROL)
                        & (payload == FLAG_CLEAR);
    cmd.read_control  = bus_sel & ~bus_wr & ~bus_addr[1] & (bus_word | ~bus_addr[0]);
  end
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
  parameter int SEL_W = 3,
  localparam int DIV_W = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] pcount_q;
  logic [DIV_W-1:0] pcount_d;
  logic [DIV_W-1:0] mask;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (sel >= SEL_W'(i));
  end

  always_comb begin
    pcount_d = en ? pcount_q + DIV_W'(1) : '0;
    tick     = en & ((pcount_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcount_q <= '0;
    else        pcount_q <= pcount_d;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | tick;
    cnt_d  = load ? load_val : cnt_q + CNT_W'(1);
    wrap   = tick & ~load & (cnt_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int LEN = 6,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;

  always_comb begin
    if (fire)              left_d = CW'(LEN);
    else if (left_q != '0) left_d = left_q - CW'(1);
    else                   left_d = '0;
    active = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int PULSE_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wdt_reset_o
);
  localparam int CNT_W = BYTE_W;

  wdk_cmd_t cmd;
  logic mode_q, mode_d, en_q, en_d, rsten_q, rsten_d;
  logic ovf_q, ovf_d, arm_q, arm_d, wrst_q, wrst_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic tick, wrap, wd_fire, ovf_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] rbytes [4];

  wdk_bus_decode u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmd       (cmd)
  );

  wdk_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .sel   (sel_q),
    .tick  (tick)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd.load_count),
    .load_val (bus_wdata[CNT_W-1:0]),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .wrap     (wrap)
  );

  assign wd_fire = wrap & mode_q & rsten_q;

  wdk_pulse #(.LEN(PULSE_CYCLES)) u_pls (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (wd_fire),
    .active (wdt_reset_o)
  );

  always_comb begin
    mode_d  = mode_q;
    en_d    = en_q;
    rsten_d = rsten_q;
    sel_d   = sel_q;
    if (cmd.load_control) begin
      mode_d  = bus_wdata[CTL_MODE];
      en_d    = bus_wdata[CTL_EN];
      rsten_d = bus_wdata[CTL_RSTEN];
      sel_d   = bus_wdata[SEL_W-1:0];
    end
    ovf_clr = cmd.load_control & ~bus_wdata[CTL_OVF] & arm_q;
    ovf_d   = wrap | (ovf_q & ~ovf_clr);
    arm_d   = ovf_clr ? 1'b0 : (arm_q | (cmd.read_control & ovf_q));
    wrst_d  = wd_fire | (wrst_q & ~cmd.clear_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      sel_q   <= '0;
      ovf_q   <= 1'b0;
      arm_q   <= 1'b0;
      wrst_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      rsten_q <= rsten_d;
      sel_q   <= sel_d;
      ovf_q   <= ovf_d;
      arm_q   <= arm_d;
      wrst_q  <= wrst_d;
    end
  end

  always_comb begin
    rbytes[0] = {ovf_q, mode_q, en_q, rsten_q, 1'b1, sel_q};
    rbytes[1] = cnt_q;
    rbytes[2] = {wrst_q, 1'b0, 6'h3F};
    rbytes[3] = '0;
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_word) bus_rdata = {rbytes[{bus_addr[1], 1'b0}], rbytes[{bus_addr[1], 1'b1}]};
      else          bus_rdata = {8'h00, rbytes[bus_addr]};
    end
  end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_word,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [6:0]  status_rd,
  input logic [7:0]  cnt_q,
  input logic        en_q,
  input logic        ovf_q,
  input logic        wrst_q,
  input logic        wdt_reset_o
);
  logic word_wr0, flag_clear, ovf_clear_try;

  assign word_wr0      = bus_sel && bus_wr && bus_word && bus_addr == 2'd0;
  assign flag_clear    = bus_sel && bus_wr && bus_word && bus_addr == 2'd2 && bus_wdata == 16'hA500;
  assign ovf_clear_try = word_wr0 && bus_wdata[15:8] == 8'hA5 && !bus_wdata[7];

  AST_COUNT_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr0 && bus_wdata[15:8] == 8'h5A) |=> (cnt_q == $past(bus_wdata[7:0]))); // R2

  AST_BAD_KEY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr0 && bus_wdata[15:8] != 8'h5A && !en_q) |=> $stable(cnt_q)); // R3

  AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word && !en_q) |=> $stable(cnt_q)); // R4

  AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_word && bus_addr == 2'd2) |-> (status_rd == 7'h3F)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrst_q && !flag_clear) |=> wrst_q); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clear_try) |=> ovf_q); // R8

  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset_o) |-> wrst_q); // R9
endmodule

bind keyed_watchdog wdk_checker u_wdk_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_word    (bus_word),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .status_rd   (bus_rdata[6:0]),
  .cnt_q       (cnt_q),
  .en_q        (en_q),
  .ovf_q       (ovf_q),
  .wrst_q      (wrst_q),
  .wdt_reset_o (wdt_reset_o)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  localparam int PULSE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdt_reset_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  keyed_watchdog #(.PULSE_CYCLES(PULSE)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_o(wdt_reset_o)
  );

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [1:0] a, input logic word, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic word, input logic [15:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_check(input logic exp, input string tag);
    #1;
    n_tests++;
    if (wdt_reset_o !== exp) begin
      n_fail++;
      $display("FAIL %s wdt_reset_o actual=%0b expected=%0b", tag, wdt_reset_o, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read is on the bus
  always begin
    logic [15:0] e;
    string t;
    @(negedge clk);
    #2;
    if (bus_sel && !bus_wr) begin
      n_tests++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL run-timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 1'b1, 16'h0800, "R1 ctrl/count");
    rd(2'd2, 1'b1, 16'h3F00, "R1 status");
    pin_check(1'b0, "R1");
    step(1);
    // R2 counter key
    wr(2'd0, 1'b1, 16'h5A37);
    rd(2'd1, 1'b0, 16'h0037, "R2 counter load");
    // R3 bad key, control key
    wr(2'd0, 1'b1, 16'h1299);
    rd(2'd0, 1'b1, 16'h0837, "R3 bad key ignored");
    wr(2'd0, 1'b1, 16'hA507);
    rd(2'd0, 1'b0, 16'h000F, "R3 control load");
    wr(2'd0, 1'b1, 16'hA500);
    // R4 byte writes and odd word write
    wr(2'd0, 1'b0, 16'h5A55);
    wr(2'd1, 1'b0, 16'hA555);
    rd(2'd0, 1'b1, 16'h0837, "R4 byte writes ignored");
    wr(2'd1, 1'b1, 16'h5A11);
    rd(2'd1, 1'b0, 16'h0037, "R4 odd word write ignored");
    // R10 read map
    rd(2'd3, 1'b0, 16'h0000, "R10 byte 3");
    rd(2'd3, 1'b1, 16'h3F00, "R10 odd word read");
    // R6 counting, select 1 -> every 4 cycles
    wr(2'd0, 1'b1, 16'h5A10);
    wr(2'd0, 1'b1, 16'hA521);
    rd(2'd1, 1'b0, 16'h0010, "R6 start");
    step(2);
    rd(2'd1, 1'b0, 16'h0010, "R6 before first tick");
    rd(2'd1, 1'b0, 16'h0011, "R6 first tick");
    wr(2'd0, 1'b1, 16'hA501);
    step(10);
    rd(2'd1, 1'b0, 16'h0011, "R6 hold when disabled");
    // R7 overflow in interval mode, select 0
    wr(2'd0, 1'b1, 16'h5AFE);
    wr(2'd0, 1'b1, 16'hA520);
    rd(2'd0, 1'b1, 16'h28FE, "R6 select 0 start");
    step(2);
    rd(2'd1, 1'b0, 16'h00FF, "R6 select 0 tick");
    rd(2'd1, 1'b0, 16'h0000, "R7 wrap");
    pin_check(1'b0, "R9 interval no pulse");
    step(1);
    // R8 clear-only overflow flag
    wr(2'd0, 1'b1, 16'hA500);
    rd(2'd2, 1'b0, 16'h003F, "R9 interval no flag");
    rd(2'd0, 1'b0, 16'h0088, "R8 unread clear ignored / R7 flag");
    wr(2'd0, 1'b1, 16'hA580);
    rd(2'd0, 1'b0, 16'h0088, "R8 write 1 ignored");
    wr(2'd0, 1'b1, 16'hA500);
    rd(2'd0, 1'b0, 16'h0008, "R8 clear after read");
    // R9 watchdog reset pulse
    wr(2'd0, 1'b1, 16'h5AFF);
    wr(2'd0, 1'b1, 16'hA570);
    pin_check(1'b0, "R9 before wrap");
    step(1);
    pin_check(1'b0, "R9 before wrap");
    step(1);
    pin_check(1'b1, "R9 pulse start");
    step(PULSE - 1);
    pin_check(1'b1, "R9 pulse last cycle");
    step(1);
    pin_check(1'b0, "R9 pulse end");
    rd(2'd2, 1'b0, 16'h00BF, "R9 flag set");
    wr(2'd0, 1'b1, 16'hA500);
    // R5 flag clearing
    wr(2'd2, 1'b1, 16'hA501);
    rd(2'd2, 1'b0, 16'h00BF, "R5 wrong data");
    wr(2'd2, 1'b0, 16'hA500);
    rd(2'd2, 1'b0, 16'h00BF, "R5 byte write");
    wr(2'd2, 1'b1, 16'h5A00);
    rd(2'd2, 1'b0, 16'h00BF, "R5 wrong key");
    wr(2'd2, 1'b1, 16'hA500);
    rd(2'd2, 1'b0, 16'h003F, "R5 cleared");
    step(3);
    if (q_exp.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q_exp.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule